// File: doc/BRIEF.md
# Multi-Page-Size Translation Cache

This block is a small, fully associative cache of DMA address translations. It holds the results of I/O page-table walks for three page sizes at once: 4 KiB, 2 MiB and 1 GiB. Each slot records the requesting source ID, the owning domain ID, the level-masked page frame, the page level, the leaf base address and the read and write permissions.

A device-side lookup presents a source ID and an address and gets back, in the same cycle, a hit flag, the page-aligned input address, the page-aligned translated base, the offset mask of the matched page and a permission code. A page walker installs new translations through a fill port. Software-driven invalidation comes in through a third port, either for one domain and an address range or for the whole cache.

Top module: `xc_mps_tlb`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses.
- R2: On a hit, `lk_iova` is the lookup address with the page offset cleared, `lk_xlat` is the stored leaf address with the page offset cleared, `lk_amask` has ones exactly on the page-offset bits, and `lk_perm` has bit 1 set for write and bit 0 set for read. On a miss, or when `lk_valid` is low, `lk_hit` and all four result outputs are zero.
- R3: Level code 1 is a 4 KiB page (12 offset bits), code 2 a 2 MiB page (21 offset bits) and code 3 a 1 GiB page (30 offset bits). A lookup outside the stored page misses.
- R4: Levels are probed from code 1 upward and the smallest matching page wins. The same frame number stored at two levels gives two separate slots.
- R5: A slot only matches a lookup whose source ID equals the slot's source ID.
- R6: A fill whose source ID, level and level-masked frame equal those of a valid slot overwrites that slot in place.
- R7: When a fill matches no valid slot, the 16 slots are allocated in round-robin order from slot 0, so the 17th distinct fill after reset evicts the first one.
- R8: A page-selective invalidation with order `inv_am` removes every slot of domain `inv_did` whose 4 KiB frame number equals that of `inv_addr` once the low `inv_am` bits of both are ignored. Slots of other domains stay.
- R9: A page-selective invalidation also removes a large-page slot of the matching domain when `inv_addr` falls inside that slot's page.
- R10: A global invalidation (`inv_global` high) removes every slot, whatever the domain and address.
- R11: When a fill and an invalidation occur in the same cycle, the invalidation is applied first and the filled translation remains.
- R12: A fill whose level code is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_sid | input | SID_W | Lookup source ID |
| lk_addr | input | ADDR_W | Lookup input address |
| lk_hit | output | 1 | Lookup hit |
| lk_iova | output | ADDR_W | Page-aligned input address |
| lk_xlat | output | ADDR_W | Page-aligned translated address |
| lk_amask | output | ADDR_W | Page offset mask |
| lk_perm | output | 2 | Permission code (bit 1 write, bit 0 read) |
| fill_valid | input | 1 | Fill request |
| fill_sid | input | SID_W | Fill source ID |
| fill_did | input | DID_W | Fill domain ID |
| fill_addr | input | ADDR_W | Input address that was walked |
| fill_level | input | 2 | Leaf level code (1, 2 or 3) |
| fill_leaf | input | ADDR_W | Leaf base address |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| inv_valid | input | 1 | Invalidation request |
| inv_global | input | 1 | Invalidate all slots |
| inv_did | input | DID_W | Domain to invalidate |
| inv_addr | input | ADDR_W | Address to invalidate |
| inv_am | input | AM_W | Invalidation range order in 4 KiB pages |

## Verification
On every cycle the assertions check that a hit only follows a request, that a miss drives zero results, that a hit returns one of the three legal offset masks with both returned addresses aligned to it, that a global invalidation without a fill empties the cache, that a legal fill leaves at least one valid slot, and that no cycle adds more than one valid slot. Which slot a lookup selects when several levels match, in-place replacement, round-robin eviction order, the range and large-page rules of page-selective invalidation, and the ordering of a fill against an invalidation in the same cycle can only be shown by the bench's directed scenarios with computed expected values.

// File: rtl/xc_pkg.sv
package xc_pkg;

  localparam int unsigned BASE_SHIFT = 12;
  localparam int unsigned IDX_BITS   = 9;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_4K   = 2'd1,
    LVL_2M   = 2'd2,
    LVL_1G   = 2'd3
  } xc_level_e;

  // Number of page-offset bits for a level code.
  function automatic int unsigned lvl_shift(input logic [1:0] lvl);
    if (lvl == 2'd0) return BASE_SHIFT;
    return BASE_SHIFT + (32'(lvl) - 32'd1) * IDX_BITS;
  endfunction

endpackage

// File: rtl/xc_entry_cmp.sv
module xc_entry_cmp
  import xc_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int SID_W   = 16,
  parameter int DID_W   = 16,
  parameter int AM_W    = 6,
  parameter int FRAME_W = 36
) (
  input  logic               ent_valid,
  input  logic [SID_W-1:0]   ent_sid,
  input  logic [DID_W-1:0]   ent_did,
  input  logic [FRAME_W-1:0] ent_frame,
  input  logic [1:0]         ent_level,
  input  logic               lk_valid,
  input  logic [SID_W-1:0]   lk_sid,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic [SID_W-1:0]   fill_sid,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [1:0]         fill_level,
  input  logic [DID_W-1:0]   inv_did,
  input  logic [ADDR_W-1:0]  inv_addr,
  input  logic [AM_W-1:0]    inv_am,
  output logic               lk_match,
  output logic               fill_match,
  output logic               inv_match
);

  logic [ADDR_W-1:0]  ent_pmask;
  logic [ADDR_W-1:0]  lk_masked;
  logic [ADDR_W-1:0]  inv_masked;
  logic [FRAME_W-1:0] inv_frame;
  logic [FRAME_W-1:0] am_mask;
  logic               range_hit;
  logic               cover_hit;

  assign ent_pmask  = {ADDR_W{1'b1}} << lvl_shift(ent_level);
  assign lk_masked  = lk_addr & ent_pmask;
  assign inv_masked = inv_addr & ent_pmask;
  assign inv_frame  = inv_addr[ADDR_W-1:BASE_SHIFT];

  always_comb begin
    for (int i = 0; i < FRAME_W; i++) begin
      am_mask[i] = (i >= int'(inv_am));
    end
  end

  assign lk_match   = ent_valid && lk_valid && (ent_sid == lk_sid) &&
                      (ent_frame == lk_masked[ADDR_W-1:BASE_SHIFT]);
  assign fill_match = ent_valid && (ent_sid == fill_sid) &&
                      (ent_level == fill_level) && (ent_frame == fill_frame);
  assign range_hit  = ((ent_frame & am_mask) == (inv_frame & am_mask));
  assign cover_hit  = (ent_frame == inv_masked[ADDR_W-1:BASE_SHIFT]);
  assign inv_match  = ent_valid && (ent_did == inv_did) && (range_hit || cover_hit);

endmodule

// File: rtl/xc_hit_select.sv
module xc_hit_select #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0]      match,
  input  logic [ENTRIES-1:0][1:0] level,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);

  // Walk from the largest page and highest slot downward so the last
  // assignment is the smallest level, lowest slot.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int l = 3; l >= 1; l--) begin
      for (int i = ENTRIES - 1; i >= 0; i--) begin
        if (match[i] && (level[i] == 2'(l))) begin
          hit = 1'b1;
          idx = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/xc_rr_ptr.sv
module xc_rr_ptr #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/xc_mps_tlb.sv
module xc_mps_tlb
  import xc_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int SID_W   = 16,
  parameter int DID_W   = 16,
  parameter int AM_W    = 6,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [SID_W-1:0]  lk_sid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_iova,
  output logic [ADDR_W-1:0] lk_xlat,
  output logic [ADDR_W-1:0] lk_amask,
  output logic [1:0]        lk_perm,
  input  logic              fill_valid,
  input  logic [SID_W-1:0]  fill_sid,
  input  logic [DID_W-1:0]  fill_did,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_level,
  input  logic [ADDR_W-1:0] fill_leaf,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              inv_valid,
  input  logic              inv_global,
  input  logic [DID_W-1:0]  inv_did,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [AM_W-1:0]   inv_am
);

  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int FRAME_W = ADDR_W - BASE_SHIFT;

  // Slot state: valid has reset, payload is loaded under fill enable.
  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0]              valid_d;
  logic [ENTRIES-1:0][SID_W-1:0]   sid_q;
  logic [ENTRIES-1:0][DID_W-1:0]   did_q;
  logic [ENTRIES-1:0][FRAME_W-1:0] frame_q;
  logic [ENTRIES-1:0][1:0]         lvl_q;
  logic [ENTRIES-1:0][ADDR_W-1:0]  leaf_q;
  logic [ENTRIES-1:0]              rd_q;
  logic [ENTRIES-1:0]              wr_q;

  logic [ENTRIES-1:0] lk_vec;
  logic [ENTRIES-1:0] fill_vec;
  logic [ENTRIES-1:0] inv_vec;

  logic [ADDR_W-1:0]  fill_pmask;
  logic [ADDR_W-1:0]  fill_masked;
  logic [FRAME_W-1:0] fill_frame;
  logic               fill_ok;
  logic               fill_any;
  logic [IDX_W-1:0]   fill_idx;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   widx;

  logic               sel_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [ADDR_W-1:0]  sel_pmask;

  assign fill_pmask  = {ADDR_W{1'b1}} << lvl_shift(fill_level);
  assign fill_masked = fill_addr & fill_pmask;
  assign fill_frame  = fill_masked[ADDR_W-1:BASE_SHIFT];
  assign fill_ok     = fill_valid && (fill_level != LVL_NONE);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    xc_entry_cmp #(
      .ADDR_W (ADDR_W),
      .SID_W  (SID_W),
      .DID_W  (DID_W),
      .AM_W   (AM_W),
      .FRAME_W(FRAME_W)
    ) u_cmp (
      .ent_valid (valid_q[g]),
      .ent_sid   (sid_q[g]),
      .ent_did   (did_q[g]),
      .ent_frame (frame_q[g]),
      .ent_level (lvl_q[g]),
      .lk_valid  (lk_valid),
      .lk_sid    (lk_sid),
      .lk_addr   (lk_addr),
      .fill_sid  (fill_sid),
      .fill_frame(fill_frame),
      .fill_level(fill_level),
      .inv_did   (inv_did),
      .inv_addr  (inv_addr),
      .inv_am    (inv_am),
      .lk_match  (lk_vec[g]),
      .fill_match(fill_vec[g]),
      .inv_match (inv_vec[g])
    );
  end

  xc_hit_select #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sel (
    .match(lk_vec),
    .level(lvl_q),
    .hit  (sel_hit),
    .idx  (sel_idx)
  );

  xc_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (fill_ok && !fill_any),
    .ptr  (rr_ptr)
  );

  // Slot already holding the fill key, lowest index first.
  always_comb begin
    fill_any = 1'b0;
    fill_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_vec[i]) begin
        fill_any = 1'b1;
        fill_idx = IDX_W'(i);
      end
    end
  end

  assign widx = fill_any ? fill_idx : rr_ptr;

  // Next valid state: invalidation first, then the fill.
  always_comb begin
    valid_d = valid_q;
    if (inv_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_global || inv_vec[i]) valid_d[i] = 1'b0;
      end
    end
    if (fill_ok) valid_d[widx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      sid_q[widx]   <= fill_sid;
      did_q[widx]   <= fill_did;
      frame_q[widx] <= fill_frame;
      lvl_q[widx]   <= fill_level;
      leaf_q[widx]  <= fill_leaf;
      rd_q[widx]    <= fill_rd;
      wr_q[widx]    <= fill_wr;
    end
  end

  assign sel_pmask = {ADDR_W{1'b1}} << lvl_shift(lvl_q[sel_idx]);
  assign lk_hit    = sel_hit;
  assign lk_iova   = sel_hit ? (lk_addr & sel_pmask) : '0;
  assign lk_xlat   = sel_hit ? (leaf_q[sel_idx] & sel_pmask) : '0;
  assign lk_amask  = sel_hit ? ~sel_pmask : '0;
  assign lk_perm   = sel_hit ? {wr_q[sel_idx], rd_q[sel_idx]} : 2'b00;

endmodule

// File: rtl/xc_mps_tlb_chk.sv
module xc_mps_tlb_chk #(
  parameter int ADDR_W  = 48,
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic [ADDR_W-1:0]  lk_iova,
  input logic [ADDR_W-1:0]  lk_xlat,
  input logic [ADDR_W-1:0]  lk_amask,
  input logic [1:0]         lk_perm,
  input logic               fill_valid,
  input logic [1:0]         fill_level,
  input logic               inv_valid,
  input logic               inv_global,
  input logic [ENTRIES-1:0] valid_q
);

  p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_amask == '0 && lk_xlat == '0 && lk_iova == '0 && lk_perm == 2'b00));

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_iova & lk_amask) == '0 && (lk_xlat & lk_amask) == '0));

  p_mask_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_amask == ADDR_W'(64'hFFF) || lk_amask == ADDR_W'(64'h1F_FFFF) ||
                lk_amask == ADDR_W'(64'h3FFF_FFFF)));

  p_global_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_global && !fill_valid) |=> (valid_q == '0));

  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_level != 2'd0) |=> (valid_q != '0));

  p_one_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(valid_q) <= $countones($past(valid_q)) + 1));

endmodule

bind xc_mps_tlb xc_mps_tlb_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_hit    (lk_hit),
  .lk_iova   (lk_iova),
  .lk_xlat   (lk_xlat),
  .lk_amask  (lk_amask),
  .lk_perm   (lk_perm),
  .fill_valid(fill_valid),
  .fill_level(fill_level),
  .inv_valid (inv_valid),
  .inv_global(inv_global),
  .valid_q   (valid_q)
);

// File: tb/xc_mps_tlb_bench.sv
`timescale 1ns/1ps
module xc_mps_tlb_bench;

  localparam int ADDR_W = 48;
  localparam int SID_W  = 16;
  localparam int DID_W  = 16;
  localparam int AM_W   = 6;

  localparam logic [ADDR_W-1:0] M4K = 48'hFFF;
  localparam logic [ADDR_W-1:0] M2M = 48'h1F_FFFF;
  localparam logic [ADDR_W-1:0] M1G = 48'h3FFF_FFFF;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lk_valid;
  logic [SID_W-1:0]  lk_sid;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic [ADDR_W-1:0] lk_iova;
  logic [ADDR_W-1:0] lk_xlat;
  logic [ADDR_W-1:0] lk_amask;
  logic [1:0]        lk_perm;
  logic              fill_valid;
  logic [SID_W-1:0]  fill_sid;
  logic [DID_W-1:0]  fill_did;
  logic [ADDR_W-1:0] fill_addr;
  logic [1:0]        fill_level;
  logic [ADDR_W-1:0] fill_leaf;
  logic              fill_rd;
  logic              fill_wr;
  logic              inv_valid;
  logic              inv_global;
  logic [DID_W-1:0]  inv_did;
  logic [ADDR_W-1:0] inv_addr;
  logic [AM_W-1:0]   inv_am;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xc_mps_tlb u_xc_mps_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_sid(lk_sid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_iova(lk_iova), .lk_xlat(lk_xlat),
    .lk_amask(lk_amask), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_sid(fill_sid), .fill_did(fill_did),
    .fill_addr(fill_addr), .fill_level(fill_level), .fill_leaf(fill_leaf),
    .fill_rd(fill_rd), .fill_wr(fill_wr),
    .inv_valid(inv_valid), .inv_global(inv_global), .inv_did(inv_did),
    .inv_addr(inv_addr), .inv_am(inv_am)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [SID_W-1:0] sid,
                      input logic [ADDR_W-1:0] addr, input bit exp_hit,
                      input logic [ADDR_W-1:0] exp_xlat,
                      input logic [ADDR_W-1:0] exp_amask,
                      input logic [1:0] exp_perm);
    @(negedge clk);
    lk_valid = 1'b1; lk_sid = sid; lk_addr = addr;
    #1;
    chk(req, "hit", 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) begin
      chk(req, "xlat",  64'(lk_xlat),  64'(exp_xlat));
      chk(req, "amask", 64'(lk_amask), 64'(exp_amask));
      chk(req, "perm",  64'(lk_perm),  64'(exp_perm));
      chk(req, "iova",  64'(lk_iova),  64'(addr & ~exp_amask));
    end
    lk_valid = 1'b0;
  endtask

  task automatic miss(input string req, input logic [SID_W-1:0] sid,
                      input logic [ADDR_W-1:0] addr);
    look(req, sid, addr, 1'b0, '0, '0, 2'b00);
  endtask

  task automatic drive_fill(input logic [SID_W-1:0] sid, input logic [DID_W-1:0] did,
                            input logic [ADDR_W-1:0] addr, input logic [1:0] lvl,
                            input logic [ADDR_W-1:0] leaf, input bit rd, input bit wr);
    fill_valid = 1'b1; fill_sid = sid; fill_did = did; fill_addr = addr;
    fill_level = lvl; fill_leaf = leaf; fill_rd = rd; fill_wr = wr;
  endtask

  task automatic drive_inv(input bit glob, input logic [DID_W-1:0] did,
                           input logic [ADDR_W-1:0] addr, input logic [AM_W-1:0] am);
    inv_valid = 1'b1; inv_global = glob; inv_did = did; inv_addr = addr; inv_am = am;
  endtask

  task automatic idle_ports();
    fill_valid = 1'b0; inv_valid = 1'b0; inv_global = 1'b0;
  endtask

  task automatic fill(input logic [SID_W-1:0] sid, input logic [DID_W-1:0] did,
                      input logic [ADDR_W-1:0] addr, input logic [1:0] lvl,
                      input logic [ADDR_W-1:0] leaf, input bit rd, input bit wr);
    @(negedge clk);
    drive_fill(sid, did, addr, lvl, leaf, rd, wr);
    @(negedge clk);
    idle_ports();
  endtask

  task automatic inval(input bit glob, input logic [DID_W-1:0] did,
                       input logic [ADDR_W-1:0] addr, input logic [AM_W-1:0] am);
    @(negedge clk);
    drive_inv(glob, did, addr, am);
    @(negedge clk);
    idle_ports();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1
  task automatic t_reset();
    miss("R1", 16'd1, 48'h0000_1234_5000);
    miss("R1", 16'd0, 48'h0);
  endtask

  // R2, R3: one page of each size
  task automatic t_sizes();
    fill(16'd1, 16'd5, 48'h0000_1234_5000, 2'd1, 48'h0000_ABCD_E000, 1'b1, 1'b0);
    look("R2", 16'd1, 48'h0000_1234_5ABC, 1'b1, 48'h0000_ABCD_E000, M4K, 2'b01);
    miss("R3", 16'd1, 48'h0000_1234_6000);
    fill(16'd2, 16'd5, 48'h0000_8060_0000, 2'd2, 48'h0001_0020_0123, 1'b1, 1'b1);
    look("R3", 16'd2, 48'h0000_807F_FFF0, 1'b1, 48'h0001_0020_0000, M2M, 2'b11);
    miss("R3", 16'd2, 48'h0000_8080_0000);
    fill(16'd3, 16'd5, 48'h0000_C000_0000, 2'd3, 48'h0002_4000_0000, 1'b0, 1'b1);
    look("R3", 16'd3, 48'h0000_F000_1234, 1'b1, 48'h0002_4000_0000, M1G, 2'b10);
    // R2: no request, no hit
    @(negedge clk);
    lk_valid = 1'b0; lk_sid = 16'd3; lk_addr = 48'h0000_F000_1234;
    #1;
    chk("R2", "hit without request", 64'(lk_hit), 64'd0);
  endtask

  // R4
  task automatic t_priority();
    fill(16'd4, 16'd8, 48'h0000_0020_0000, 2'd2, 48'h0005_0000_0000, 1'b1, 1'b1);
    fill(16'd4, 16'd8, 48'h0000_0020_3000, 2'd1, 48'h0007_7777_7000, 1'b1, 1'b0);
    look("R4", 16'd4, 48'h0000_0020_3456, 1'b1, 48'h0007_7777_7000, M4K, 2'b01);
    look("R4", 16'd4, 48'h0000_0020_4000, 1'b1, 48'h0005_0000_0000, M2M, 2'b11);
    fill(16'd4, 16'd8, 48'h0000_0020_0000, 2'd1, 48'h0006_0000_1000, 1'b1, 1'b0);
    look("R4", 16'd4, 48'h0000_0020_0010, 1'b1, 48'h0006_0000_1000, M4K, 2'b01);
    look("R4", 16'd4, 48'h0000_0020_1000, 1'b1, 48'h0005_0000_0000, M2M, 2'b11);
  endtask

  // R5
  task automatic t_sid();
    miss("R5", 16'd5, 48'h0000_1234_5000);
    miss("R5", 16'd2, 48'h0000_1234_5000);
  endtask

  // R6
  task automatic t_replace();
    fill(16'd1, 16'd5, 48'h0000_1234_5FFF, 2'd1, 48'h0000_1111_1000, 1'b1, 1'b1);
    look("R6", 16'd1, 48'h0000_1234_5000, 1'b1, 48'h0000_1111_1000, M4K, 2'b11);
  endtask

  // R8
  task automatic t_inv_range();
    inval(1'b0, 16'd9, 48'h0000_1234_5000, 6'd0);
    look("R8", 16'd1, 48'h0000_1234_5000, 1'b1, 48'h0000_1111_1000, M4K, 2'b11);
    inval(1'b0, 16'd5, 48'h0000_1234_5000, 6'd0);
    miss("R8", 16'd1, 48'h0000_1234_5000);
    look("R8", 16'd2, 48'h0000_8060_0000, 1'b1, 48'h0001_0020_0000, M2M, 2'b11);
    for (int k = 0; k < 5; k++) begin
      if (k != 2)
        fill(16'd6, 16'd7, 48'h0000_0010_0000 + 48'(k) * 48'h1000, 2'd1,
             48'h0003_0000_0000 + 48'(k) * 48'h1000, 1'b1, 1'b0);
    end
    inval(1'b0, 16'd7, 48'h0000_0010_0000, 6'd2);
    miss("R8", 16'd6, 48'h0000_0010_0000);
    miss("R8", 16'd6, 48'h0000_0010_1000);
    miss("R8", 16'd6, 48'h0000_0010_3000);
    look("R8", 16'd6, 48'h0000_0010_4000, 1'b1, 48'h0003_0000_4000, M4K, 2'b01);
  endtask

  // R9
  task automatic t_inv_cover();
    inval(1'b0, 16'd8, 48'h0000_0020_4000, 6'd0);
    miss("R9", 16'd4, 48'h0000_0020_4000);
    look("R9", 16'd4, 48'h0000_0020_3456, 1'b1, 48'h0007_7777_7000, M4K, 2'b01);
    look("R9", 16'd4, 48'h0000_0020_0010, 1'b1, 48'h0006_0000_1000, M4K, 2'b01);
  endtask

  // R7
  task automatic t_evict();
    do_reset();
    for (int k = 0; k < 16; k++) begin
      fill(16'd9, 16'd1, 48'h0000_0050_0000 + 48'(k) * 48'h1000, 2'd1,
           48'h0009_0000_0000 + 48'(k) * 48'h1000, 1'b1, 1'b1);
    end
    look("R7", 16'd9, 48'h0000_0050_0000, 1'b1, 48'h0009_0000_0000, M4K, 2'b11);
    look("R7", 16'd9, 48'h0000_0050_F000, 1'b1, 48'h0009_0000_F000, M4K, 2'b11);
    fill(16'd9, 16'd1, 48'h0000_0051_0000, 2'd1, 48'h0009_0001_0000, 1'b1, 1'b1);
    miss("R7", 16'd9, 48'h0000_0050_0000);
    look("R7", 16'd9, 48'h0000_0050_1000, 1'b1, 48'h0009_0000_1000, M4K, 2'b11);
    look("R7", 16'd9, 48'h0000_0051_0000, 1'b1, 48'h0009_0001_0000, M4K, 2'b11);
    fill(16'd9, 16'd1, 48'h0000_0051_1000, 2'd1, 48'h0009_0001_1000, 1'b1, 1'b1);
    miss("R7", 16'd9, 48'h0000_0050_1000);
    look("R7", 16'd9, 48'h0000_0050_2000, 1'b1, 48'h0009_0000_2000, M4K, 2'b11);
  endtask

  // R10
  task automatic t_global();
    inval(1'b1, 16'd77, 48'h0, 6'd0);
    miss("R10", 16'd9, 48'h0000_0050_2000);
    miss("R10", 16'd9, 48'h0000_0051_0000);
  endtask

  // R11
  task automatic t_same_cycle();
    fill(16'd10, 16'd3, 48'h0000_0000_3000, 2'd1, 48'h0000_0AAA_0000, 1'b1, 1'b0);
    @(negedge clk);
    drive_inv(1'b0, 16'd3, 48'h0000_0000_3000, 6'd0);
    drive_fill(16'd10, 16'd3, 48'h0000_0000_3000, 2'd1, 48'h0000_0BBB_0000, 1'b1, 1'b1);
    @(negedge clk);
    idle_ports();
    look("R11", 16'd10, 48'h0000_0000_3000, 1'b1, 48'h0000_0BBB_0000, M4K, 2'b11);
    @(negedge clk);
    drive_inv(1'b1, 16'd0, 48'h0, 6'd0);
    drive_fill(16'd10, 16'd3, 48'h0000_0000_4000, 2'd1, 48'h0000_0CCC_0000, 1'b0, 1'b1);
    @(negedge clk);
    idle_ports();
    miss("R11", 16'd10, 48'h0000_0000_3000);
    look("R11", 16'd10, 48'h0000_0000_4000, 1'b1, 48'h0000_0CCC_0000, M4K, 2'b10);
  endtask

  // R12
  task automatic t_level0();
    fill(16'd11, 16'd3, 48'h0000_0000_5000, 2'd0, 48'h0000_0DDD_0000, 1'b1, 1'b1);
    miss("R12", 16'd11, 48'h0000_0000_5000);
    miss("R12", 16'd11, 48'h0000_0000_0000);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_sid = '0; lk_addr = '0;
    fill_sid = '0; fill_did = '0; fill_addr = '0; fill_level = '0;
    fill_leaf = '0; fill_rd = 1'b0; fill_wr = 1'b0;
    inv_did = '0; inv_addr = '0; inv_am = '0;
    idle_ports();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sizes();
    t_priority();
    t_sid();
    t_replace();
    t_inv_range();
    t_inv_cover();
    t_evict();
    t_global();
    t_same_cycle();
    t_level0();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before all scenarios ended");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule